// File: doc/BRIEF.md
# Interrupt Exception Window Gate

This block qualifies a pending interrupt request before the processor's dispatch logic acts on it. Some instruction events must be followed immediately by the next instruction, with no interrupt between them. A prefix-register write is one such event, because the held prefix value is good for one cycle only. A memory access through the code pointer is the other, because that instruction may also be using the stack. Each of these events, when it happens on an advancing execution cycle, makes the next execution cycle a protected window. No interrupt is accepted during a window.

A request that arrives during a window is not dropped. The request is level-sensitive and stays pending, so it is accepted on the first advancing cycle that is not a window. The block also holds the prefix value and its valid flag for the single cycle in which the prefix may be used. When the cycle-advance enable is low, the cycle is a stall: the window and prefix state hold, strobes are ignored, and nothing is accepted. Priority resolution, vectoring and context save are left to downstream logic.

Top module: `irq_window_gate`

## Requirements
- R1: A prefix write (`pfx_wr` high while `adv` is high) makes the next execution cycle a window, so `in_window` reads 1 after that clock edge.
- R2: A code-pointer access (`cp_acc` high while `adv` is high) makes the next execution cycle a window.
- R3: A prefix write loads `pfx_din` into `pfx_q` and sets `pfx_vld` for exactly one execution cycle. The next advancing cycle without a prefix write clears `pfx_vld`.
- R4: Only `pfx_wr` and `cp_acc` open a window. An advancing cycle with neither strobe, whatever `irq_req` is, leaves `in_window` at 0 on the next cycle.
- R5: A request that is pending during a window is held, not lost. It is accepted on the next advancing non-window cycle, one cycle later than it would have been without the window.
- R6: Window events on back-to-back advancing cycles chain their windows. Acceptance waits for the first advancing cycle that is not a window.
- R7: While `adv` is low, `in_window`, `pfx_vld` and `pfx_q` hold their values, the strobes have no effect, and `irq_take` stays 0.
- R8: `irq_take` is high for one cycle only when `irq_req` is high, `adv` is high and `in_window` is 0. It pulses once for each period that the request is held high, and it re-arms only after `irq_req` has been seen low at a clock edge.
- R9: An active-high synchronous `rst` clears `in_window` and `pfx_vld`, re-arms acceptance, and holds `irq_take` at 0 while it is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Execution cycle advances this clock |
| pfx_wr | input | 1 | Prefix register is written this cycle |
| pfx_din | input | PFX_W | Value written to the prefix register |
| cp_acc | input | 1 | Code memory is accessed through the code pointer this cycle |
| irq_req | input | 1 | Pending interrupt request, level-sensitive |
| irq_take | output | 1 | Interrupt accepted this cycle, single-cycle pulse |
| in_window | output | 1 | Current cycle is a protected window |
| pfx_vld | output | 1 | Held prefix value is usable this cycle |
| pfx_q | output | PFX_W | Held prefix value |

## Verification
On every cycle, the assertions check the following: a window follows each advancing prefix write or code-pointer access; acceptance never coincides with a window; an accept pulse never lasts two cycles; the prefix valid flag clears after one execution cycle; stalls leave the window flag unchanged; reset clears the state. Some behaviours span several cycles and only the bench's scenarios can show them. These are deferral without loss, the single added cycle of latency, chaining across consecutive events, the re-arm after the request drops, and strobes being ignored during a stall.

// File: rtl/irq_window_gate.sv
module irq_window_gate #(
  parameter int PFX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             pfx_wr,
  input  logic [PFX_W-1:0] pfx_din,
  input  logic             cp_acc,
  input  logic             irq_req,
  output logic             irq_take,
  output logic             in_window,
  output logic             pfx_vld,
  output logic [PFX_W-1:0] pfx_q
);

  logic             win_q;
  logic             vld_q;
  logic             armed_q;
  logic [PFX_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= 1'b0;
      vld_q   <= 1'b0;
      armed_q <= 1'b1;
      val_q   <= '0;
    end else begin
      if (adv) begin
        win_q <= pfx_wr | cp_acc;
        vld_q <= pfx_wr;
        if (pfx_wr) val_q <= pfx_din;
      end
      if (irq_take)     armed_q <= 1'b0;
      else if (!irq_req) armed_q <= 1'b1;
    end
  end

  assign irq_take  = irq_req & armed_q & adv & ~win_q & ~rst;
  assign in_window = win_q;
  assign pfx_vld   = vld_q;
  assign pfx_q     = val_q;

  // R1
  pfx_opens_window_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && pfx_wr) |=> (in_window && pfx_vld));

  // R2
  cp_opens_window_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && cp_acc) |=> in_window);

  // R3
  pfx_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !pfx_wr) |=> !pfx_vld);

  // R4
  quiet_no_window_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !pfx_wr && !cp_acc) |=> !in_window);

  // R7
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(in_window) && $stable(pfx_vld)));

  // R8
  take_outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (!in_window && irq_req && adv));

  // R8
  take_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!in_window && !pfx_vld));

endmodule

// File: tb/irq_window_gate_bench.sv
module irq_window_gate_bench;
  localparam int PFX_W = 8;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0, pfx_wr = 1'b0, cp_acc = 1'b0, irq_req = 1'b0;
  logic [PFX_W-1:0] pfx_din = '0;
  logic irq_take, in_window, pfx_vld;
  logic [PFX_W-1:0] pfx_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_window_gate #(.PFX_W(PFX_W)) u_irq_window_gate (
    .clk(clk), .rst(rst), .adv(adv), .pfx_wr(pfx_wr), .pfx_din(pfx_din),
    .cp_acc(cp_acc), .irq_req(irq_req), .irq_take(irq_take),
    .in_window(in_window), .pfx_vld(pfx_vld), .pfx_q(pfx_q)
  );

  // {adv, pfx_wr, cp_acc, irq_req, exp_window, exp_take, exp_pfx_vld}
  localparam logic [6:0] VEC [NV] = '{
    7'b1000_000, 7'b1100_000, 7'b1001_101, 7'b1001_010,
    7'b1001_000, 7'b1000_000, 7'b1010_000, 7'b1101_100,
    7'b1011_101, 7'b1001_100, 7'b1001_010, 7'b1000_000,
    7'b1001_010, 7'b1000_000, 7'b1100_000, 7'b0001_101,
    7'b0011_101, 7'b1001_101, 7'b1001_010, 7'b0110_000,
    7'b1000_000, 7'b0001_000, 7'b1001_010, 7'b1000_000
  };

  function automatic string tag(int i);
    case (i)
      2:             return "R1 R3 R5";
      3, 4, 5:       return "R4 R5 R8";
      7:             return "R2";
      8, 9, 10:      return "R6";
      12:            return "R8";
      15, 16, 17:    return "R7";
      18:            return "R5 R7";
      19, 20, 21:    return "R7";
      22:            return "R8";
      default:       return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [PFX_W-1:0] act,
                     input logic [PFX_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R9", "reset window", {7'b0, in_window}, 8'h0);
    chk("R9", "reset pfx_vld", {7'b0, pfx_vld}, 8'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {adv, pfx_wr, cp_acc, irq_req} = VEC[i][6:3];
      #1;
      chk(tag(i), $sformatf("vec %0d window", i), {7'b0, in_window}, {7'b0, VEC[i][2]});
      chk(tag(i), $sformatf("vec %0d take", i), {7'b0, irq_take}, {7'b0, VEC[i][1]});
      chk(tag(i), $sformatf("vec %0d pfx_vld", i), {7'b0, pfx_vld}, {7'b0, VEC[i][0]});
    end

    // R3 prefix value captured and held for one cycle
    @(negedge clk);
    {adv, pfx_wr, cp_acc, irq_req} = 4'b1100;
    pfx_din = 8'h5A;
    @(negedge clk);
    pfx_wr = 1'b0;
    pfx_din = 8'hC3;
    #1;
    chk("R3", "pfx_q value", pfx_q, 8'h5A);
    chk("R3", "pfx_vld set", {7'b0, pfx_vld}, 8'h1);

    // R7 stalled write does not load the prefix value
    @(negedge clk);
    {adv, pfx_wr} = 2'b01;
    @(negedge clk);
    {adv, pfx_wr} = 2'b00;
    #1;
    chk("R7", "pfx_q unchanged on stall", pfx_q, 8'h5A);
    chk("R7", "pfx_vld cleared before stall", {7'b0, pfx_vld}, 8'h0);

    // R9 reset during an open window
    @(negedge clk);
    {adv, pfx_wr, cp_acc, irq_req} = 4'b1010;
    @(negedge clk);
    {adv, pfx_wr, cp_acc, irq_req} = 4'b1001;
    #1;
    chk("R9", "window open before reset", {7'b0, in_window}, 8'h1);
    rst = 1'b1;
    #1;
    chk("R9", "no take during reset", {7'b0, irq_take}, 8'h0);
    @(negedge clk);
    #1;
    chk("R9", "window cleared by reset", {7'b0, in_window}, 8'h0);
    chk("R9", "no take while reset held", {7'b0, irq_take}, 8'h0);
    rst = 1'b0;
    #1;
    chk("R9", "take after reset release", {7'b0, irq_take}, 8'h1);
    @(negedge clk);
    irq_req = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule